// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block turns a parallel word into a serial bit stream. A low level on the load strobe copies the parallel bus into the register straight away, with no clock edge needed. Once the strobe is released, each rising clock edge taken while the enable is low moves the word one stage towards the output. The bit at the output end leaves first, and the serial input fills the stages that empty behind it. When the enable is high, the word stays where it is.

Two outputs come from the final stage: its true value and its complement. Several copies can be chained by wiring one serial output to the next serial input. The chain then acts as one longer register, driven by shared clock, load and enable lines.

Top module: `piso_shreg`

## Requirements
- R1: While `load_n` is low, bit WIDTH-1 of `par_in` appears on `ser_out` in the same time step that `load_n` falls, before any clock edge.
- R2: With `load_n` held low, rising clock edges change nothing, whatever `en_n` and `ser_in` do. The register keeps the parallel word, provided `par_in` does not change.
- R3: When `load_n` is high and `en_n` is low at a rising clock edge, stage 0 takes `ser_in` and each stage k (k ≥ 1) takes the old value of stage k-1. `ser_out` then shows the old value of stage WIDTH-2.
- R4: When `load_n` is high and `en_n` is high at a rising clock edge, the register contents stay the same.
- R5: While the clock stays high, changes on `en_n` and `ser_in` leave the outputs unchanged.
- R6: `ser_out_n` is always the logical complement of `ser_out`.
- R7: The first bit presented serially after a load is bit WIDTH-1 of the loaded word.
- R8: After the load is released, WIDTH enabled edges bring out the loaded bits in order from WIDTH-1 down to 0. The next edges bring out the `ser_in` values in the order they were applied.
- R9: Two instances, the first one's `ser_out` tied to the second one's `ser_in`, act as a 2·WIDTH-bit shift register. The second instance's word sits in the upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, acts on its rising edge |
| load_n | input | 1 | Asynchronous parallel load, active low |
| en_n | input | 1 | Shift enable, active low, sampled at the rising clock edge |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | WIDTH | Parallel word; bit WIDTH-1 ends up in the output stage |
| ser_out | output | 1 | Value of the last stage |
| ser_out_n | output | 1 | Complement of the last stage |

## Verification
The bench builds two instances with the default WIDTH of 8 and chains them. This makes the 16-bit cascade of R9 visible at the far serial output, alongside the 8-bit behaviour at the link between the two instances. Keeping the width small lets a full unload, with serial fill-in behind it, fit in a few dozen cycles. This also leaves time to pause the clock at its high level, to load while the clock keeps running, and to run a long pseudo-random mix of enable and serial values against the reference model.

// File: rtl/piso_shreg.sv
module piso_shreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             load_n,
  input  logic             en_n,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out,
  output logic             ser_out_n
);
  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] stages;

  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n)
      stages <= par_in;
    else if (!en_n)
      stages <= {stages[LAST-1:0], ser_in};
  end

  assign ser_out   = stages[LAST];
  assign ser_out_n = ~stages[LAST];

  logic armed   = 1'b0;
  logic armed_q = 1'b0;
  always_ff @(negedge load_n) armed <= 1'b1;
  always_ff @(posedge clk) armed_q <= armed;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!armed_q)
    (!load_n && !$past(load_n) && $stable(par_in)) |-> (ser_out == par_in[LAST])); // R2
  AST_SHIFT_OUT: assert property (@(posedge clk) disable iff (!armed_q)
    (load_n && $past(load_n) && !$past(en_n)) |-> (ser_out == $past(stages[LAST-1]))); // R3
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!armed_q)
    (load_n && $past(load_n) && !$past(en_n)) |-> (stages[0] == $past(ser_in))); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!armed_q)
    (load_n && $past(load_n) && $past(en_n)) |-> $stable(stages)); // R4
endmodule

// File: tb/piso_shreg_test.sv
`timescale 1ns/1ps
module piso_shreg_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic clk_run = 1'b1;
  always begin
    #4;
    if (clk_run) clk = ~clk;
  end

  logic load_n = 1'b1, en_n = 1'b1, ser_in = 1'b0;
  logic [W-1:0] par_a = '0, par_b = '0;
  logic link, out_a_n, out_b, out_b_n;

  piso_shreg #(.WIDTH(W)) uut (.clk(clk), .load_n(load_n), .en_n(en_n), .ser_in(ser_in),
    .par_in(par_a), .ser_out(link), .ser_out_n(out_a_n));
  piso_shreg #(.WIDTH(W)) nxt (.clk(clk), .load_n(load_n), .en_n(en_n), .ser_in(link),
    .par_in(par_b), .ser_out(out_b), .ser_out_n(out_b_n));

  int checks = 0, failures = 0;
  bit done = 0, mvalid = 0;
  string req = "R3";
  logic [2*W-1:0] m;

  task automatic check(string r, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s t=%0t actual=%b expected=%b", r, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    check(req, link, m[W-1]);
    check("R6", out_a_n, ~m[W-1]);
    check(req == "R3" ? "R9" : req, out_b, m[2*W-1]);
    check("R6", out_b_n, ~m[2*W-1]);
  endtask

  always @(negedge load_n) m = {par_b, par_a};
  always @(posedge clk) begin
    if (!load_n) m = {par_b, par_a};
    else if (!en_n) m = {m[2*W-2:0], ser_in};
    if (mvalid) begin
      #3;
      compare_all();
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    logic [W-1:0] sbits;
    logic held_a, held_b;
    logic [2*W-1:0] word;
    repeat (2) @(negedge clk);

    // R1 / R7: load seen without a clock edge
    @(negedge clk);
    par_a = 8'hA5; par_b = 8'h3C; load_n = 1'b0;
    #1;
    check("R1", link, 1'b1);
    check("R7", link, par_a[W-1]);
    check("R1", out_b, par_b[W-1]);
    check("R6", out_a_n, ~par_a[W-1]);
    mvalid = 1;

    // R2: load held low while clock runs, enable and serial toggling
    req = "R2";
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      en_n = i[0]; ser_in = ~i[0];
      check("R2", link, par_a[W-1]);
      check("R2", out_b, par_b[W-1]);
    end

    // R8: unload in order, then serial fill-in
    @(negedge clk);
    load_n = 1'b1; en_n = 1'b0;
    req = "R8";
    sbits = 8'b1100_1010;
    for (int i = 0; i < W; i++) begin
      check("R8", link, par_a[W-1-i]);
      ser_in = sbits[W-1-i];
      @(negedge clk);
    end
    for (int i = 0; i < 3; i++) begin
      check("R8", link, sbits[W-1-i]);
      @(negedge clk);
    end

    // R4: enable high mid-sequence holds
    req = "R4";
    en_n = 1'b1;
    held_a = link; held_b = out_b;
    for (int i = 0; i < 3; i++) begin
      ser_in = ~ser_in;
      @(negedge clk);
      check("R4", link, held_a);
      check("R4", out_b, held_b);
    end
    req = "R3";
    en_n = 1'b0;
    repeat (2) @(negedge clk);

    // R5: clock parked high
    @(posedge clk);
    clk_run = 1'b0;
    #1;
    held_a = link; held_b = out_b;
    for (int i = 0; i < 4; i++) begin
      #5; en_n = ~en_n; ser_in = ~ser_in;
      #1;
      check("R5", link, held_a);
      check("R5", out_b, held_b);
      check("R6", out_a_n, ~link);
    end
    en_n = 1'b0;
    clk_run = 1'b1;
    @(negedge clk);

    // R9: chained pair as 16-bit register
    par_a = 8'h96; par_b = 8'h71; load_n = 1'b0;
    @(negedge clk);
    load_n = 1'b1; en_n = 1'b0; ser_in = 1'b0;
    req = "R9";
    word = {par_b, par_a};
    for (int i = 0; i < 2*W; i++) begin
      check("R9", out_b, word[2*W-1-i]);
      @(negedge clk);
    end
    check("R9", out_b, 1'b0);

    // R3: pseudo-random enable and serial mix
    req = "R3";
    lfsr = 8'h5B;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      ser_in = lfsr[0];
      en_n = lfsr[6] & lfsr[2];
      @(negedge clk);
    end

    mvalid = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule